// File: doc/BRIEF.md
# Segmented Lookahead Incrementer/Decrementer

This block adds or subtracts a single carry-in to a 16-bit value. Instead of a single 16-stage ripple, the carry path is cut into three groups plus a lone top bit. The low seven bits ripple. Every higher group takes its carry from an AND-of-propagates lookahead term that spans all the bits beneath it. As a result, no output bit sits behind a long chain of cells, and the bits settle at roughly the same time.

Three controls set the operation. A direction input picks count up or count down. A carry-in enable with value zero turns the block into a pass-through, so a captured value can be read back without change. A refresh control stops the carry into bit 7. In refresh mode the low seven bits act as a free-running 7-bit counter, and the upper nine bits hold the value presented at the input. The arithmetic is combinational. The result is captured in one output register so the block fits a registered FPGA pipeline.

Top module: `incdec_seg`

## Requirements
- R1: While `rst` is high at a clock edge, `val_out` becomes 0x0000 after that edge.
- R2: With `cin`=1, `dir_dec`=0 and `refresh`=0, `val_out` equals (`val_in` + 1) mod 2^16 one clock after the inputs are sampled.
- R3: With `cin`=1, `dir_dec`=1 and `refresh`=0, `val_out` equals (`val_in` - 1) mod 2^16 one clock later.
- R4: With `cin`=0, `val_out` equals `val_in` one clock later, whatever the values of `dir_dec` and `refresh`.
- R5: With `refresh`=1, `val_out[15:7]` equals `val_in[15:7]` one clock later, in either direction.
- R6: With `refresh`=1 and `cin`=1, `val_out[6:0]` equals (`val_in[6:0]` ± 1) mod 2^7 one clock later. The sign is + when `dir_dec`=0 and - when `dir_dec`=1.
- R7: A carry or borrow crosses every group boundary correctly in normal mode. Incrementing 0x007F gives 0x0080, 0x0FFF gives 0x1000, 0x7FFF gives 0x8000 and 0xFFFF gives 0x0000. Decrementing 0x0000 gives 0xFFFF and 0x8000 gives 0x7FFF.
- R8: In refresh mode the low field wraps without touching bit 7. Incrementing 0x007F gives 0x0000, and decrementing 0xFF80 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| val_in | input | 16 | Operand |
| dir_dec | input | 1 | 0 counts up, 1 counts down |
| cin | input | 1 | Carry/borrow-in enable; 0 passes the operand through |
| refresh | input | 1 | 1 blocks the carry into bit 7 (7-bit counter mode) |
| val_out | output | 16 | Registered result |

## Verification
When a group's lookahead term or its refresh gate is wrong, the fault shows up exactly one clock later as a bad bit field in `val_out`. The damage stays inside the group that received the bad carry: bits 7–11, bits 12–14, or bit 15. Such a fault appears only for operands whose lower bits all propagate, so a random value hits it rarely. The directed boundary operands (all ones or all zeros below a boundary) make each lookahead term fire in both directions. In refresh mode, any carry that leaks into bit 7 changes the upper nine bits on the very next cycle.

// File: rtl/incdec_pkg.sv
package incdec_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  // Bit that propagates a carry (up) or borrow (down).
  function automatic logic prop_bit(input logic a, input dir_e d);
    return (d == DIR_UP) ? a : ~a;
  endfunction
endpackage

// File: rtl/incdec_ripple.sv
module incdec_ripple
  import incdec_pkg::*;
#(
  parameter int N = 7
) (
  input  logic [N-1:0] a,
  input  logic         dir_dec,
  input  logic         cin,
  output logic [N-1:0] y,
  output logic [N-1:0] prop
);
  logic [N-1:0] c;
  dir_e         dir;

  assign dir  = dir_e'(dir_dec);
  assign c[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_cell
    assign prop[i] = prop_bit(a[i], dir);
    assign y[i]    = a[i] ^ c[i];
    if (i < N - 1) begin : g_chain
      assign c[i+1] = c[i] & prop[i];
    end
  end
endmodule

// File: rtl/incdec_lookahead.sv
module incdec_lookahead #(
  parameter int N = 5
) (
  input  logic [N-1:0] prop,
  output logic         all_prop
);
  // Wide NOR of the kill terms: the group passes a carry only if no bit kills it.
  assign all_prop = ~|(~prop);
endmodule

// File: rtl/incdec_seg.sv
module incdec_seg #(
  parameter int LO_W  = 7,
  parameter int MID_W = 5,
  parameter int HI_W  = 3,
  parameter int W     = LO_W + MID_W + HI_W + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] val_in,
  input  logic         dir_dec,
  input  logic         cin,
  input  logic         refresh,
  output logic [W-1:0] val_out
);
  localparam int MID_LSB = LO_W;
  localparam int HI_LSB  = LO_W + MID_W;
  localparam int TOP_BIT = W - 1;

  logic [LO_W-1:0]  lo_y,  lo_p;
  logic [MID_W-1:0] mid_y, mid_p;
  logic [HI_W-1:0]  hi_y,  hi_p;
  logic             lo_all, mid_all, hi_all;
  logic             c_mid, c_hi, c_top;
  logic [W-1:0]     sum;

  // Low group: plain ripple, sees the external carry directly.
  incdec_ripple #(.N(LO_W)) u_lo (
    .a(val_in[LO_W-1:0]), .dir_dec(dir_dec), .cin(cin),
    .y(lo_y), .prop(lo_p)
  );
  incdec_lookahead #(.N(LO_W)) u_la_lo (.prop(lo_p), .all_prop(lo_all));

  // Refresh gate sits on the lookahead carry into the middle group.
  assign c_mid = cin & ~refresh & lo_all;

  incdec_ripple #(.N(MID_W)) u_mid (
    .a(val_in[HI_LSB-1:MID_LSB]), .dir_dec(dir_dec), .cin(c_mid),
    .y(mid_y), .prop(mid_p)
  );
  incdec_lookahead #(.N(MID_W)) u_la_mid (.prop(mid_p), .all_prop(mid_all));
  assign c_hi = c_mid & mid_all;

  incdec_ripple #(.N(HI_W)) u_hi (
    .a(val_in[TOP_BIT-1:HI_LSB]), .dir_dec(dir_dec), .cin(c_hi),
    .y(hi_y), .prop(hi_p)
  );
  incdec_lookahead #(.N(HI_W)) u_la_hi (.prop(hi_p), .all_prop(hi_all));
  assign c_top = c_hi & hi_all;

  assign sum = {val_in[TOP_BIT] ^ c_top, hi_y, mid_y, lo_y};

  always_ff @(posedge clk) begin
    if (rst) val_out <= '0;
    else     val_out <= sum;
  end
endmodule

// File: rtl/incdec_seg_chk.sv
module incdec_seg_chk #(
  parameter int W    = 16,
  parameter int LO_W = 7
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] val_in,
  input logic         dir_dec,
  input logic         cin,
  input logic         refresh,
  input logic [W-1:0] val_out
);
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cin && !dir_dec && !refresh) |=> val_out == W'($past(val_in) + W'(1))); // R2
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cin && dir_dec && !refresh) |=> val_out == W'($past(val_in) - W'(1))); // R3
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !cin |=> val_out == $past(val_in)); // R4
  AST_REFRESH_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    refresh |=> val_out[W-1:LO_W] == $past(val_in[W-1:LO_W])); // R5
  AST_REFRESH_LOW_COUNT: assert property (@(posedge clk) disable iff (rst)
    (cin && refresh) |=> val_out[LO_W-1:0] ==
      ($past(dir_dec) ? LO_W'($past(val_in[LO_W-1:0]) - LO_W'(1))
                      : LO_W'($past(val_in[LO_W-1:0]) + LO_W'(1)))); // R6
endmodule

bind incdec_seg incdec_seg_chk #(.W(W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst(rst), .val_in(val_in), .dir_dec(dir_dec),
  .cin(cin), .refresh(refresh), .val_out(val_out)
);

// File: tb/sim_incdec_seg.sv
`timescale 1ns/1ps
module sim_incdec_seg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] val_in = '0;
  logic        dir_dec = 1'b0, cin = 1'b0, refresh = 1'b0;
  logic [15:0] val_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  incdec_seg u0 (.clk(clk), .rst(rst), .val_in(val_in), .dir_dec(dir_dec),
                 .cin(cin), .refresh(refresh), .val_out(val_out));

  function automatic logic [15:0] ref_model(input logic [15:0] v, input logic d,
                                            input logic c, input logic r);
    logic [15:0] full;
    full = d ? v - 16'(c) : v + 16'(c);
    return r ? {v[15:7], full[6:0]} : full;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] v, input logic d,
                       input logic c, input logic r);
    @(negedge clk);
    val_in = v; dir_dec = d; cin = c; refresh = r;
    @(negedge clk);
    check(req, val_out, ref_model(v, d, c, r));
    if (r) check("R5", {val_out[15:7], 7'h0}, {v[15:7], 7'h0});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic d, c, r;
    string tag;
    void'($urandom(32'd1234));
    val_in = 16'hABCD; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", val_out, 16'h0000);
    rst = 1'b0;

    // R7 boundary crossings
    apply("R7", 16'h007F, 0, 1, 0);
    apply("R7", 16'h0FFF, 0, 1, 0);
    apply("R7", 16'h7FFF, 0, 1, 0);
    apply("R7", 16'hFFFF, 0, 1, 0);
    apply("R7", 16'h0000, 1, 1, 0);
    apply("R7", 16'h8000, 1, 1, 0);
    apply("R7", 16'h1000, 1, 1, 0);
    apply("R7", 16'h0080, 1, 1, 0);
    // R8 refresh wrap
    apply("R8", 16'h007F, 0, 1, 1);
    apply("R8", 16'hFF80, 1, 1, 1);
    apply("R8", 16'hFFFF, 0, 1, 1);
    apply("R8", 16'h0000, 1, 1, 1);
    // R4 pass-through on corners, all mode combinations
    apply("R4", 16'hFFFF, 0, 0, 0);
    apply("R4", 16'h0000, 1, 0, 0);
    apply("R4", 16'h7FFF, 0, 0, 1);
    apply("R4", 16'h0FFF, 1, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      v = 16'($urandom);
      d = 1'($urandom); c = 1'($urandom); r = 1'($urandom);
      if (i % 4 == 0) v = v | 16'h007F;   // bias toward carry out of low group
      if (i % 4 == 1) v = v & 16'hFF80;   // bias toward borrow out of low group
      if (!c)     tag = "R4";
      else if (r) tag = "R6";
      else if (d) tag = "R3";
      else        tag = "R2";
      apply(tag, v, d, c, r);
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", val_out, 16'h0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule